// File: doc/BRIEF.md
# Threshold-Driven Byte Buffer for a Floppy Controller Data Path

This block sits between the host bus and the serial disk engine of a floppy disk controller. Every byte that crosses the controller goes through it: command parameters on their way in, sector data in either direction, and result bytes on their way out. A ring of byte storage holds the data. A service request tells the host, or a DMA engine, when enough bytes, or enough free space, have built up to make a transfer worthwhile. The point at which that happens is a programmable threshold.

The buffer has two operating widths. After any reset, and always during a command phase, it holds a single byte, so parameters move one at a time. Once an execution phase starts, and only if software has turned the deep mode on, the full depth is available. Each phase boundary empties the buffer so that no stale bytes leak into the next transfer.

When the disk side outruns the host, the block flags an overrun on reads. When it starves, the block flags an underrun on writes. After a read overrun the host may still drain what is left. After a write underrun the disk side receives zero bytes until the next phase starts, so the sector can be closed with padding. A lock setting keeps the deep-mode enable and the threshold across a software reset.

Top module: `sbf_top`

## Requirements
- R1: After the asynchronous reset `rst_n` is released, `fill_level` is 0, `svc_req`, `overrun` and `underrun` are 0, and the configuration is in single-byte mode with the lock cleared.
- R2: Outside an execution phase, or when deep mode is disabled, the buffer holds at most one byte. A write offered while it holds that byte is ignored. `svc_req` is 0 whenever no execution phase is active.
- R3: In an execution phase with deep mode enabled, up to DEPTH (16) bytes are held and leave in the order they arrived. `fill_level` reports the count after each accepted byte, one clock after the accepting edge.
- R4: In the read direction (`dir_to_host`=1), the threshold is `cfg_thr`+1 bytes in deep mode and 1 byte in single-byte mode. `svc_req` is 1 while the fill level is at or above the threshold.
- R5: In the write direction (`dir_to_host`=0), `svc_req` is 1 while the free space (capacity minus fill level) is at or above the same threshold. It drops one clock after the host write that takes the free space below it, and returns after the disk-side pull that restores it.
- R6: A pulse on `phase_exec`, `phase_cmd` or `soft_rst` empties the buffer and clears both error flags by the next clock.
- R7: In the read direction during an execution phase, a `disk_push` while the buffer is full sets `overrun`, and the byte is dropped. Later pushes are ignored. `svc_req` then stays 1 for as long as any byte remains, so the host can drain it.
- R8: In the write direction during an execution phase, a `disk_pull` while the buffer is empty sets `underrun`. From then until the next phase pulse, `disk_rdata` is 0x00, host writes are ignored, and `svc_req` is 0.
- R9: `soft_rst` returns the enable and threshold to single-byte mode unless the lock bit, loaded with `cfg_wr`, is set. When the lock is set, both settings survive the reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, clears everything including the lock |
| soft_rst | input | 1 | Synchronous software reset pulse |
| cfg_wr | input | 1 | Loads `cfg_en`, `cfg_thr` and `cfg_lock` |
| cfg_en | input | 1 | Deep-mode enable |
| cfg_thr | input | 4 | Threshold code; the threshold is code+1 bytes |
| cfg_lock | input | 1 | Keep enable and threshold across `soft_rst` |
| dir_to_host | input | 1 | 1 = disk to host (read), 0 = host to disk (write) |
| phase_cmd | input | 1 | Pulse at the start of a command phase |
| phase_exec | input | 1 | Pulse at the start of an execution phase |
| host_wr | input | 1 | Host writes `host_wdata` (write direction) |
| host_wdata | input | 8 | Host write byte |
| host_rd | input | 1 | Host takes the head byte (read direction) |
| host_rdata | output | 8 | Head byte toward the host, 0 when empty |
| disk_push | input | 1 | Disk engine delivers `disk_wdata` (read direction) |
| disk_wdata | input | 8 | Byte from the disk engine |
| disk_pull | input | 1 | Disk engine takes the head byte (write direction) |
| disk_rdata | output | 8 | Head byte toward the disk, 0 when empty or after underrun |
| svc_req | output | 1 | Service request to host or DMA |
| overrun | output | 1 | Sticky read overrun flag |
| underrun | output | 1 | Sticky write underrun flag |
| fill_level | output | 5 | Number of bytes held |

## Verification
A corrupted pointer or level count shows up at the ports at once. The next host read returns a byte out of order, or `fill_level` departs from the running count, on the clock right after the faulty edge. A wrong capacity or threshold decision shows as `svc_req` switching one byte early or late, or as an overrun arriving at the wrong fill. A lost mode or error state (single-byte mode, lock, padding) becomes visible on the first byte offered after the phase or reset pulse, because that byte is then accepted or refused.

// File: rtl/sbf_pkg.sv
package sbf_pkg;
   typedef enum logic {
      DIR_TO_DISK = 1'b0,
      DIR_TO_HOST = 1'b1
   } xfer_dir_e;
endpackage

// File: rtl/sbf_store.sv
// Ring storage with a level counter; the wrap variant is chosen by generate.
module sbf_store #(
   parameter int WIDTH = 8,
   parameter int DEPTH = 16
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         flush,
   input  logic                         push,
   input  logic                         pop,
   input  logic [WIDTH-1:0]             wdata,
   output logic [WIDTH-1:0]             head,
   output logic [$clog2(DEPTH+1)-1:0]   level
);
   localparam int PTR_W = $clog2(DEPTH);
   localparam int LVL_W = $clog2(DEPTH+1);
   localparam bit POW2  = (DEPTH & (DEPTH - 1)) == 0;

   logic [WIDTH-1:0] mem [DEPTH];
   logic [PTR_W-1:0] wr_ptr, rd_ptr, wr_nxt, rd_nxt;

   generate
      if (POW2) begin : g_wrap_natural
         assign wr_nxt = wr_ptr + PTR_W'(1);
         assign rd_nxt = rd_ptr + PTR_W'(1);
      end else begin : g_wrap_compare
         assign wr_nxt = (wr_ptr == PTR_W'(DEPTH-1)) ? '0 : wr_ptr + PTR_W'(1);
         assign rd_nxt = (rd_ptr == PTR_W'(DEPTH-1)) ? '0 : rd_ptr + PTR_W'(1);
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (push) mem[wr_ptr] <= wdata;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         level  <= '0;
      end else if (flush) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         level  <= '0;
      end else begin
         if (push) wr_ptr <= wr_nxt;
         if (pop)  rd_ptr <= rd_nxt;
         case ({push, pop})
            2'b10:   level <= level + LVL_W'(1);
            2'b01:   level <= level - LVL_W'(1);
            default: level <= level;
         endcase
      end
   end

   assign head = (level != '0) ? mem[rd_ptr] : '0;

   assert_level_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
      level <= LVL_W'(DEPTH));

   assert_level_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (push && !pop && !flush) |=> level == $past(level) + LVL_W'(1));

   assert_flush_empty_R6: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> level == '0);
endmodule

// File: rtl/sbf_ctrl.sv
// Configuration registers, lock, phase tracking, capacity and threshold.
module sbf_ctrl #(
   parameter int DEPTH = 16
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         soft_rst,
   input  logic                         cfg_wr,
   input  logic                         cfg_en,
   input  logic [$clog2(DEPTH)-1:0]     cfg_thr,
   input  logic                         cfg_lock,
   input  logic                         phase_cmd,
   input  logic                         phase_exec,
   output logic                         in_exec,
   output logic                         flush,
   output logic [$clog2(DEPTH+1)-1:0]   cap,
   output logic [$clog2(DEPTH+1)-1:0]   thr
);
   localparam int THR_W = $clog2(DEPTH);
   localparam int LVL_W = $clog2(DEPTH+1);

   logic             en_q, lock_q, fifo_on;
   logic [THR_W-1:0] thr_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q   <= 1'b0;
         thr_q  <= '0;
         lock_q <= 1'b0;
      end else if (soft_rst) begin
         if (!lock_q) begin
            en_q  <= 1'b0;
            thr_q <= '0;
         end
      end else if (cfg_wr) begin
         en_q   <= cfg_en;
         thr_q  <= cfg_thr;
         lock_q <= cfg_lock;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                      in_exec <= 1'b0;
      else if (soft_rst || phase_cmd)  in_exec <= 1'b0;
      else if (phase_exec)             in_exec <= 1'b1;
   end

   assign flush   = soft_rst | phase_cmd | phase_exec;
   assign fifo_on = en_q & in_exec;
   assign cap     = fifo_on ? LVL_W'(DEPTH) : LVL_W'(1);
   assign thr     = fifo_on ? (LVL_W'(thr_q) + LVL_W'(1)) : LVL_W'(1);

   assert_lock_keep_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (soft_rst && lock_q) |=> (en_q == $past(en_q)) && (thr_q == $past(thr_q)));

   assert_unlock_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (soft_rst && !lock_q) |=> !en_q && (thr_q == '0));

   assert_cmd_bytemode_R2: assert property (@(posedge clk) disable iff (!rst_n)
      phase_cmd |=> !fifo_on);
endmodule

// File: rtl/sbf_flow.sv
// Direction steering, acceptance, service request and error flags.
module sbf_flow
   import sbf_pkg::*;
#(
   parameter int WIDTH = 8,
   parameter int DEPTH = 16
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         dir_to_host,
   input  logic                         in_exec,
   input  logic                         flush,
   input  logic [$clog2(DEPTH+1)-1:0]   cap,
   input  logic [$clog2(DEPTH+1)-1:0]   thr,
   input  logic [$clog2(DEPTH+1)-1:0]   level,
   input  logic [WIDTH-1:0]             head,
   input  logic                         host_wr,
   input  logic [WIDTH-1:0]             host_wdata,
   input  logic                         host_rd,
   input  logic                         disk_push,
   input  logic [WIDTH-1:0]             disk_wdata,
   input  logic                         disk_pull,
   output logic                         push,
   output logic                         pop,
   output logic [WIDTH-1:0]             wdata,
   output logic                         req,
   output logic                         overrun,
   output logic                         underrun,
   output logic [WIDTH-1:0]             host_rdata,
   output logic [WIDTH-1:0]             disk_rdata
);
   localparam int LVL_W = $clog2(DEPTH+1);

   xfer_dir_e  dir;
   logic       full, empty, err, wr_req, rd_req;
   logic       ovr_q, und_q, ovr_set, und_set;
   logic [LVL_W-1:0] free;

   assign dir   = xfer_dir_e'(dir_to_host);
   assign full  = level >= cap;
   assign empty = level == '0;
   assign free  = full ? '0 : cap - level;
   assign err   = ovr_q | und_q;

   always_comb begin
      if (dir == DIR_TO_HOST) begin
         wr_req = disk_push;
         rd_req = host_rd;
         wdata  = disk_wdata;
      end else begin
         wr_req = host_wr;
         rd_req = disk_pull;
         wdata  = host_wdata;
      end
   end

   assign push = wr_req & ~full & ~err & ~flush;
   assign pop  = rd_req & ~empty & ~flush;

   assign ovr_set = (dir == DIR_TO_HOST) & disk_push & full & in_exec;
   assign und_set = (dir == DIR_TO_DISK) & disk_pull & empty & in_exec;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ovr_q <= 1'b0;
         und_q <= 1'b0;
      end else if (flush) begin
         ovr_q <= 1'b0;
         und_q <= 1'b0;
      end else begin
         if (ovr_set) ovr_q <= 1'b1;
         if (und_set) und_q <= 1'b1;
      end
   end

   always_comb begin
      if (!in_exec)                req = 1'b0;
      else if (dir == DIR_TO_HOST) req = ovr_q ? ~empty : (level >= thr);
      else                         req = ~und_q & (free >= thr);
   end

   assign overrun    = ovr_q;
   assign underrun   = und_q;
   assign host_rdata = head;
   assign disk_rdata = und_q ? '0 : head;

   assert_overrun_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (dir_to_host && disk_push && (level >= cap) && in_exec && !flush) |=> overrun);

   assert_err_freeze_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (ovr_q && !flush) |=> level <= $past(level));

   assert_pad_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (und_q && !flush && !dir_to_host) |=> (level == '0) && underrun);
endmodule

// File: rtl/sbf_top.sv
module sbf_top #(
   parameter int WIDTH = 8,
   parameter int DEPTH = 16
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         soft_rst,
   input  logic                         cfg_wr,
   input  logic                         cfg_en,
   input  logic [$clog2(DEPTH)-1:0]     cfg_thr,
   input  logic                         cfg_lock,
   input  logic                         dir_to_host,
   input  logic                         phase_cmd,
   input  logic                         phase_exec,
   input  logic                         host_wr,
   input  logic [WIDTH-1:0]             host_wdata,
   input  logic                         host_rd,
   output logic [WIDTH-1:0]             host_rdata,
   input  logic                         disk_push,
   input  logic [WIDTH-1:0]             disk_wdata,
   input  logic                         disk_pull,
   output logic [WIDTH-1:0]             disk_rdata,
   output logic                         svc_req,
   output logic                         overrun,
   output logic                         underrun,
   output logic [$clog2(DEPTH+1)-1:0]   fill_level
);
   localparam int LVL_W = $clog2(DEPTH+1);

   generate
      if (DEPTH < 2) begin : g_bad_depth
         $error("sbf_top: DEPTH must be at least 2");
      end
      if (WIDTH < 1) begin : g_bad_width
         $error("sbf_top: WIDTH must be at least 1");
      end
   endgenerate

   logic             in_exec, flush, push, pop;
   logic [LVL_W-1:0] cap, thr, level;
   logic [WIDTH-1:0] wdata, head;

   sbf_ctrl #(.DEPTH(DEPTH)) ctrl_i (
      .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst),
      .cfg_wr(cfg_wr), .cfg_en(cfg_en), .cfg_thr(cfg_thr), .cfg_lock(cfg_lock),
      .phase_cmd(phase_cmd), .phase_exec(phase_exec),
      .in_exec(in_exec), .flush(flush), .cap(cap), .thr(thr)
   );

   sbf_store #(.WIDTH(WIDTH), .DEPTH(DEPTH)) store_i (
      .clk(clk), .rst_n(rst_n), .flush(flush), .push(push), .pop(pop),
      .wdata(wdata), .head(head), .level(level)
   );

   sbf_flow #(.WIDTH(WIDTH), .DEPTH(DEPTH)) flow_i (
      .clk(clk), .rst_n(rst_n), .dir_to_host(dir_to_host),
      .in_exec(in_exec), .flush(flush), .cap(cap), .thr(thr),
      .level(level), .head(head),
      .host_wr(host_wr), .host_wdata(host_wdata), .host_rd(host_rd),
      .disk_push(disk_push), .disk_wdata(disk_wdata), .disk_pull(disk_pull),
      .push(push), .pop(pop), .wdata(wdata), .req(svc_req),
      .overrun(overrun), .underrun(underrun),
      .host_rdata(host_rdata), .disk_rdata(disk_rdata)
   );

   assign fill_level = level;
endmodule

// File: tb/sbf_top_tb_top.sv
module sbf_top_tb_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       soft_rst = 0, cfg_wr = 0, cfg_en = 0, cfg_lock = 0;
   logic [3:0] cfg_thr = '0;
   logic       dir_to_host = 1'b1, phase_cmd = 0, phase_exec = 0;
   logic       host_wr = 0, host_rd = 0, disk_push = 0, disk_pull = 0;
   logic [7:0] host_wdata = '0, disk_wdata = '0;
   logic [7:0] host_rdata, disk_rdata;
   logic       svc_req, overrun, underrun;
   logic [4:0] fill_level;

   int checks = 0;
   int failures = 0;
   bit done = 0;

   always #10 clk = ~clk;

   sbf_top dut_i (
      .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .cfg_wr(cfg_wr),
      .cfg_en(cfg_en), .cfg_thr(cfg_thr), .cfg_lock(cfg_lock),
      .dir_to_host(dir_to_host), .phase_cmd(phase_cmd), .phase_exec(phase_exec),
      .host_wr(host_wr), .host_wdata(host_wdata), .host_rd(host_rd),
      .host_rdata(host_rdata), .disk_push(disk_push), .disk_wdata(disk_wdata),
      .disk_pull(disk_pull), .disk_rdata(disk_rdata), .svc_req(svc_req),
      .overrun(overrun), .underrun(underrun), .fill_level(fill_level)
   );

   // {op[1:0] (1 = disk push, 2 = host read), data[7:0], level[4:0], req}
   // Read direction, deep mode, threshold code 3 (4 bytes).
   localparam logic [15:0] VEC [10] = '{
      {2'd1, 8'hA0, 5'd1, 1'b0}, {2'd1, 8'hA1, 5'd2, 1'b0},
      {2'd1, 8'hA2, 5'd3, 1'b0}, {2'd1, 8'hA3, 5'd4, 1'b1},
      {2'd2, 8'hA0, 5'd3, 1'b0}, {2'd1, 8'hA4, 5'd4, 1'b1},
      {2'd2, 8'hA1, 5'd3, 1'b0}, {2'd2, 8'hA2, 5'd2, 1'b0},
      {2'd2, 8'hA3, 5'd1, 1'b0}, {2'd2, 8'hA4, 5'd0, 1'b0}
   };

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic cfg(input logic en, input logic [3:0] t, input logic lk);
      cfg_wr = 1; cfg_en = en; cfg_thr = t; cfg_lock = lk;
      tick();
      cfg_wr = 0;
   endtask

   task automatic pulse_exec();
      phase_exec = 1; tick(); phase_exec = 0;
   endtask

   task automatic pulse_cmd();
      phase_cmd = 1; tick(); phase_cmd = 0;
   endtask

   task automatic pulse_soft();
      soft_rst = 1; tick(); soft_rst = 0;
   endtask

   task automatic dpush(input logic [7:0] d);
      disk_push = 1; disk_wdata = d; tick(); disk_push = 0;
   endtask

   task automatic hwr(input logic [7:0] d);
      host_wr = 1; host_wdata = d; tick(); host_wr = 0;
   endtask

   task automatic hrd(input string tag, input logic [7:0] e);
      host_rd = 1; #1 chk(tag, host_rdata, e); tick(); host_rd = 0;
   endtask

   task automatic dpull(input string tag, input logic [7:0] e);
      disk_pull = 1; #1 chk(tag, disk_rdata, e); tick(); disk_pull = 0;
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      failures++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      // R1: reset state
      chk("R1 level", fill_level, 0);
      chk("R1 req", svc_req, 0);
      chk("R1 overrun", overrun, 0);
      chk("R1 underrun", underrun, 0);

      // R2 / R7: unconfigured buffer in an execution phase is one byte deep
      dir_to_host = 1;
      pulse_exec();
      dpush(8'h5A);
      chk("R2 byte level", fill_level, 1);
      chk("R4 byte thr req", svc_req, 1);
      dpush(8'h5B);
      chk("R2 byte second push overruns", overrun, 1);
      chk("R2 byte level held", fill_level, 1);
      chk("R7 drain req", svc_req, 1);
      hrd("R7 drain data", 8'h5A);
      chk("R7 drained req", svc_req, 0);

      // R2: command phase forces single byte even with deep mode on
      cfg(1'b1, 4'd0, 1'b0);
      pulse_cmd();
      dir_to_host = 0;
      chk("R6 cmd clears overrun", overrun, 0);
      hwr(8'h11);
      chk("R2 cmd level", fill_level, 1);
      chk("R2 cmd req off", svc_req, 0);
      hwr(8'h22);
      chk("R2 cmd second write ignored", fill_level, 1);

      // R6: execution start flushes; R3/R4 vector table
      cfg(1'b1, 4'd3, 1'b0);
      dir_to_host = 1;
      pulse_exec();
      chk("R6 exec flush", fill_level, 0);
      for (int i = 0; i < 10; i++) begin
         if (VEC[i][15:14] == 2'd1) dpush(VEC[i][13:6]);
         else hrd("R3 table data", VEC[i][13:6]);
         chk("R3 table level", fill_level, int'(VEC[i][5:1]));
         chk("R4 table req", svc_req, int'(VEC[i][0]));
      end

      // R3 / R7: fill to depth, overrun, drain in order
      for (int i = 0; i < 16; i++) dpush(8'h30 + 8'(i));
      chk("R3 full level", fill_level, 16);
      chk("R7 no overrun at full", overrun, 0);
      dpush(8'hEE);
      chk("R7 overrun", overrun, 1);
      chk("R7 level kept", fill_level, 16);
      for (int i = 0; i < 16; i++) begin
         hrd("R3 order", 8'h30 + 8'(i));
         if (i == 14) chk("R7 drain req at one byte", svc_req, 1);
      end
      chk("R7 empty req", svc_req, 0);

      // R5 / R8: write direction, threshold 5
      cfg(1'b1, 4'd4, 1'b0);
      dir_to_host = 0;
      pulse_exec();
      chk("R5 empty req", svc_req, 1);
      for (int i = 0; i < 11; i++) hwr(8'h40 + 8'(i));
      chk("R5 free five req", svc_req, 1);
      hwr(8'h4B);
      chk("R5 level twelve", fill_level, 12);
      chk("R5 free four req", svc_req, 0);
      dpull("R5 first out", 8'h40);
      chk("R5 req back", svc_req, 1);
      for (int i = 1; i < 12; i++) dpull("R3 write order", 8'h40 + 8'(i));
      chk("R8 no underrun yet", underrun, 0);
      dpull("R8 empty pull data", 8'h00);
      chk("R8 underrun", underrun, 1);
      chk("R8 req off", svc_req, 0);
      hwr(8'h77);
      chk("R8 host write ignored", fill_level, 0);
      dpull("R8 pad data", 8'h00);
      pulse_exec();
      chk("R6 exec clears underrun", underrun, 0);
      chk("R6 exec req", svc_req, 1);

      // R9: soft reset without lock
      cfg(1'b1, 4'd7, 1'b0);
      pulse_soft();
      dir_to_host = 1;
      pulse_exec();
      dpush(8'h01);
      chk("R9 unlocked byte mode req", svc_req, 1);
      dpush(8'h02);
      chk("R9 unlocked overrun", overrun, 1);

      // R9: soft reset with lock
      cfg(1'b1, 4'd7, 1'b1);
      pulse_soft();
      chk("R6 soft clears overrun", overrun, 0);
      pulse_exec();
      for (int i = 0; i < 7; i++) dpush(8'h60 + 8'(i));
      chk("R9 locked thr not met", svc_req, 0);
      dpush(8'h67);
      chk("R9 locked thr met", svc_req, 1);
      chk("R9 locked level", fill_level, 8);

      // R1: hard reset clears lock and config
      rst_n = 0;
      @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      chk("R1 reset level", fill_level, 0);
      chk("R1 reset req", svc_req, 0);
      pulse_exec();
      dpush(8'h81);
      dpush(8'h82);
      chk("R1 reset byte mode", overrun, 1);

      finish_run();
   end
endmodule